// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an internal synchronous request bus and an external asynchronous static RAM of 256K words by 16 bits. A requester presents one command for a single cycle while `ready` is high: a read or a write, an 18-bit word address, write data and a 2-bit lane mask. The controller turns that command into the active-low strobe pattern the memory expects. It drives chip select, write strobe, output strobe and one select line per byte lane. It drives the address, and it controls the bidirectional data bus through a separate output value, an output-enable and an input value.

Each strobe phase is held for a number of clock cycles derived from two parameters, the clock period and the memory access time, so that the 45 ns access time is met at any clock rate. Writes are framed by one setup cycle and one hold cycle, so the write strobe never overlaps an address or bus change. Reads release the bus one cycle before the output strobe falls. Read data is sampled on the last strobe cycle and returned with a single-cycle valid pulse. Whenever no access is in progress the chip is deselected, which keeps it in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and while idle, `ready` is 1, `rd_valid` is 0, all five active-low strobes (`sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n`, `sram_lb_n`) are 1 and `sram_dq_oe` is 0.
- R2: The strobe length W in clock cycles is the ceiling of ACCESS_NS / CLK_PERIOD_NS with a minimum of 1; with the defaults (45 ns, 8 ns) W is 6.
- R3: A write with a nonzero mask holds `sram_ce_n` low and `sram_dq_oe` high for W+2 cycles. In the first of them `sram_we_n` is high, in the next W it is low, and in the last it is high again. Address and `sram_dq_out` stay stable throughout, and `sram_oe_n` stays high.
- R4: Mask bit 0 selects the low lane (data bits 7:0, `sram_lb_n` low) and mask bit 1 selects the high lane (data bits 15:8, `sram_ub_n` low) whenever `sram_ce_n` is low. A write changes only the selected lanes of the addressed word.
- R5: A read with a nonzero mask holds `sram_ce_n` low for W+1 cycles with `sram_dq_oe` low and `sram_we_n` high. `sram_oe_n` is high in the first cycle and low in the following W cycles.
- R6: A read returns `rd_data` sampled from `sram_dq_in` on the last output-strobe cycle, with a one-cycle `rd_valid` pulse in the cycle after it. Bytes of lanes not selected by the mask read as zero.
- R7: `ready` is low from the cycle after acceptance until the access completes, and it is high in the cycle after the last strobe cycle. A request presented while `ready` is low is ignored, and `sram_ce_n` is high whenever `ready` is high.
- R8: A request with mask 00 never drives `sram_ce_n` low and keeps `ready` low for exactly one cycle. For a read it still pulses `rd_valid` in the next cycle with `rd_data` equal to zero. `sram_ce_n` is never low while both lane selects are high.
- R9: `sram_dq_oe` and a low `sram_oe_n` never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present; taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| ready | output | 1 | Controller idle and able to take a command |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a completed read |
| rd_data | output | 16 | Read result, unselected lanes zero |
| sram_addr | output | 18 | Memory word address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_ub_n | output | 1 | High-lane select, active low |
| sram_lb_n | output | 1 | Low-lane select, active low |
| sram_dq_out | output | 16 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 16 | Value sampled from the data bus |

## Verification
The bound checker covers the strobe relations that must hold at every edge. It checks bus drive against output strobe, the setup and hold cycles around the write strobe, the released bus before the output strobe, the strobe lengths measured by counters, standby whenever ready is high, and the shape of the read-valid pulse. Only the bench scenarios can show that the correct lanes of the correct word change in memory. They also show that read data matches what was written under every mask combination, that a command offered while busy leaves the addressed memory untouched, and that a zero-mask request finishes in one cycle with a zero result.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SKIP_WR,
      ST_SKIP_RD,
      ST_WR_SETUP,
      ST_WR_STROBE,
      ST_WR_HOLD,
      ST_RD_SETUP,
      ST_RD_STROBE
   } seq_state_t;

   // Strobe length in clock cycles: ceiling of access / period, at least one.
   function automatic int strobe_cycles(input int period_ns, input int access_ns);
      int c;
      c = (access_ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int WAIT_CYC = 6,
   localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign last = run && (cnt == CNT_W'(WAIT_CYC - 1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic req_any_lane,
   input  logic strobe_last,
   output logic ready,
   output logic accept,
   output logic chip_act,
   output logic wr_act,
   output logic rd_act,
   output logic bus_drive,
   output logic timer_run,
   output logic capture
);

   seq_state_t state_q, state_d;

   assign ready  = (state_q == ST_IDLE);
   assign accept = ready && req_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (req_any_lane) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
               else              state_d = req_write ? ST_SKIP_WR  : ST_SKIP_RD;
            end
         end
         ST_SKIP_WR:   state_d = ST_IDLE;
         ST_SKIP_RD:   state_d = ST_IDLE;
         ST_WR_SETUP:  state_d = ST_WR_STROBE;
         ST_WR_STROBE: if (strobe_last) state_d = ST_WR_HOLD;
         ST_WR_HOLD:   state_d = ST_IDLE;
         ST_RD_SETUP:  state_d = ST_RD_STROBE;
         ST_RD_STROBE: if (strobe_last) state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign bus_drive = (state_q == ST_WR_SETUP) || (state_q == ST_WR_STROBE) ||
                      (state_q == ST_WR_HOLD);
   assign chip_act  = bus_drive || (state_q == ST_RD_SETUP) || (state_q == ST_RD_STROBE);
   assign wr_act    = (state_q == ST_WR_STROBE);
   assign rd_act    = (state_q == ST_RD_STROBE);
   assign timer_run = wr_act || rd_act;
   assign capture   = (rd_act && strobe_last) || (state_q == ST_SKIP_RD);

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   localparam int LANE_W = DATA_W / LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  logic              lane_sel,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic              any_lane,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [LANES-1:0]  lane_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [LANES-1:0] be_q;

   assign any_lane = |req_be;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else if (load) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= capture;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g] = ~(lane_sel & be_q[g]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data[g*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rd_data[g*LANE_W +: LANE_W] <= be_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
         end
      end
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 8,
   parameter int ACCESS_NS     = 45
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   output logic              ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic              sram_ub_n,
   output logic              sram_lb_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int LANES    = 2;
   localparam int WAIT_CYC = sram_ctrl_pkg::strobe_cycles(CLK_PERIOD_NS, ACCESS_NS);

   if (DATA_W % LANES != 0) begin : g_bad_width
      $error("DATA_W must split evenly into byte lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (CLK_PERIOD_NS < 1 || ACCESS_NS < 1) begin : g_bad_time
      $error("clock period and access time must be positive");
   end

   logic             accept, any_lane, strobe_last;
   logic             chip_act, wr_act, rd_act, bus_drive, timer_run, capture;
   logic [LANES-1:0] lane_n;

   sram_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_any_lane (any_lane),
      .strobe_last  (strobe_last),
      .ready        (ready),
      .accept       (accept),
      .chip_act     (chip_act),
      .wr_act       (wr_act),
      .rd_act       (rd_act),
      .bus_drive    (bus_drive),
      .timer_run    (timer_run),
      .capture      (capture)
   );

   if (WAIT_CYC > 1) begin : g_timer
      sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (timer_run),
         .last  (strobe_last)
      );
   end else begin : g_single
      assign strobe_last = timer_run;
   end

   sram_lane_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .lane_sel  (chip_act),
      .capture   (capture),
      .dq_in     (sram_dq_in),
      .any_lane  (any_lane),
      .addr_q    (sram_addr),
      .wdata_q   (sram_dq_out),
      .lane_n    (lane_n),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign sram_ce_n  = ~chip_act;
   assign sram_we_n  = ~wr_act;
   assign sram_oe_n  = ~rd_act;
   assign sram_lb_n  = lane_n[0];
   assign sram_ub_n  = lane_n[1];
   assign sram_dq_oe = bus_drive;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 16,
   parameter int WAIT_CYC = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic              sram_ub_n,
   input logic              sram_lb_n,
   input logic [DATA_W-1:0] sram_dq_out,
   input logic              sram_dq_oe
);

   int we_lo_len, oe_lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_len <= 0;
         oe_lo_len <= 0;
      end else begin
         we_lo_len <= sram_we_n ? 0 : we_lo_len + 1;
         oe_lo_len <= sram_oe_n ? 0 : oe_lo_len + 1;
      end
   end

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !sram_dq_oe); // R9

   AST_WE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_ce_n && sram_dq_oe && sram_oe_n)); // R3

   AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> ($past(!sram_ce_n) && $past(sram_dq_oe) &&
                            $stable(sram_addr) && $stable(sram_dq_out))); // R3

   AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe &&
                            $stable(sram_addr) && $stable(sram_dq_out))); // R3

   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_lo_len == WAIT_CYC)); // R2

   AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> (oe_lo_len == WAIT_CYC)); // R2

   AST_OE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_oe_n) |-> ($past(!sram_ce_n) && $past(!sram_dq_oe) &&
                            $stable(sram_addr))); // R5

   AST_RDV_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> rd_valid); // R6

   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R6

   AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R7

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R3

   AST_NO_EMPTY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_ce_n |-> !(sram_ub_n && sram_lb_n)); // R8

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .WAIT_CYC (sram_ctrl_pkg::strobe_cycles(CLK_PERIOD_NS, ACCESS_NS))
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ready       (ready),
   .rd_valid    (rd_valid),
   .sram_addr   (sram_addr),
   .sram_ce_n   (sram_ce_n),
   .sram_we_n   (sram_we_n),
   .sram_oe_n   (sram_oe_n),
   .sram_ub_n   (sram_ub_n),
   .sram_lb_n   (sram_lb_n),
   .sram_dq_out (sram_dq_out),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

   localparam int AW = 18;
   localparam int DW = 16;
   localparam int PERIOD = 8;
   localparam int ACC = 45;
   localparam int W = ((ACC + PERIOD - 1) / PERIOD < 1) ? 1 : (ACC + PERIOD - 1) / PERIOD; // R2

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
   logic [DW-1:0] sram_dq_out, dq_in_r;
   logic          sram_dq_oe;

   int  n_chk = 0, n_fail = 0;
   bit  model_on = 1'b0, done = 1'b0, prev_rdv = 1'b0;
   logic [DW-1:0] mem [int];
   logic [DW-1:0] shadow [int];
   logic [DW-1:0] exp_q [$];

   always #4 clk = ~clk;

   sram_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PERIOD), .ACCESS_NS(ACC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .ready(ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_dq_out(sram_dq_out),
      .sram_dq_oe(sram_dq_oe), .sram_dq_in(dq_in_r));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mget(input int a);
      return mem.exists(a) ? mem[a] : '0;
   endfunction
   function automatic logic [DW-1:0] sget(input int a);
      return shadow.exists(a) ? shadow[a] : '0;
   endfunction

   // memory model: stores selected lanes at the end of the write strobe
   always @(posedge sram_we_n) begin
      if (model_on && !sram_ce_n) begin
         logic [DW-1:0] w;
         w = mget(int'(sram_addr));
         if (!sram_lb_n) w[7:0]  = sram_dq_out[7:0];
         if (!sram_ub_n) w[15:8] = sram_dq_out[15:8];
         mem[int'(sram_addr)] = w;
      end
   end

   // read drive, garbage on lanes that are not selected
   always @(negedge clk) begin
      logic [DW-1:0] r;
      r = mget(int'(sram_addr));
      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
         dq_in_r[7:0]  <= !sram_lb_n ? r[7:0]  : 8'h5A;
         dq_in_r[15:8] <= !sram_ub_n ? r[15:8] : 8'hA5;
      end else begin
         dq_in_r <= 16'hDEAD;
      end
   end

   // monitor: pops expected read results
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         if (rd_valid) begin
            chk(!prev_rdv, "R6 rd_valid single pulse", 32'(prev_rdv), 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected rd_valid", 1, 0);
            end else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk(rd_data == e, "R6 read data", 32'(rd_data), 32'(e));
            end
         end
         prev_rdv = rd_valid;
      end
   end

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be, input bit poke);
      int  n = 0, ce_lo = 0, we_lo = 0, oe_lo = 0;
      int  bad_addr = 0, bad_lane = 0, bad_data = 0;
      bit  first_ok = 1'b0;
      logic [DW-1:0] s, e;
      while (!ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      if (!wr) begin
         s = sget(int'(a));
         e = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
         exp_q.push_back(e);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 18'h300;
         req_wdata = 16'hEEEE; req_be = 2'b11;
      end
      while (!ready) begin
         if (n == 0) begin
            if (be == 2'b00) first_ok = sram_ce_n;
            else if (wr)     first_ok = !sram_ce_n && sram_we_n && sram_oe_n && sram_dq_oe;
            else             first_ok = !sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe;
         end
         if (!sram_ce_n) begin
            ce_lo++;
            if (sram_addr != a) bad_addr++;
            if (sram_lb_n != !be[0] || sram_ub_n != !be[1]) bad_lane++;
         end
         if (!sram_we_n) we_lo++;
         if (!sram_oe_n) oe_lo++;
         if (wr && (sram_dq_oe != (be != 2'b00))) bad_data++;
         if (wr && sram_dq_oe && sram_dq_out != d) bad_data++;
         if (!wr && sram_dq_oe) bad_data++;
         n++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      if (be == 2'b00) begin
         chk(n == 1, "R8 zero mask busy cycles", n, 1);
         chk(ce_lo == 0 && we_lo == 0 && oe_lo == 0, "R8 zero mask strobes", ce_lo + we_lo + oe_lo, 0);
      end else if (wr) begin
         chk(n == W + 2, "R7 write busy cycles", n, W + 2);
         chk(ce_lo == W + 2, "R3 write select length", ce_lo, W + 2);
         chk(we_lo == W, "R2 write strobe length", we_lo, W);
         chk(oe_lo == 0, "R3 no output strobe on write", oe_lo, 0);
         chk(first_ok, "R3 write setup cycle", 32'(first_ok), 1);
         chk(bad_data == 0, "R3 bus drive and data", bad_data, 0);
      end else begin
         chk(n == W + 1, "R7 read busy cycles", n, W + 1);
         chk(ce_lo == W + 1, "R5 read select length", ce_lo, W + 1);
         chk(oe_lo == W, "R2 output strobe length", oe_lo, W);
         chk(we_lo == 0, "R5 no write strobe on read", we_lo, 0);
         chk(first_ok, "R5 read setup cycle", 32'(first_ok), 1);
         chk(bad_data == 0, "R9 bus released on read", bad_data, 0);
      end
      chk(bad_addr == 0, "R3 address held", bad_addr, 0);
      chk(bad_lane == 0, "R4 lane selects", bad_lane, 0);
      if (!wr) chk(rd_valid == 1'b1, "R6 rd_valid with ready", 32'(rd_valid), 1);
      chk(sram_ce_n == 1'b1, "R7 standby when ready", 32'(sram_ce_n), 1);
      if (wr) begin
         s = sget(int'(a));
         if (be[0]) s[7:0]  = d[7:0];
         if (be[1]) s[15:8] = d[15:8];
         shadow[int'(a)] = s;
         chk(mget(int'(a)) == s, "R4 memory lanes", 32'(mget(int'(a))), 32'(s));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ready == 1'b1 && rd_valid == 1'b0, "R1 reset ready/rd_valid", {ready, rd_valid}, 2'b10);
      chk({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n} == 5'b11111,
          "R1 reset strobes", {sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}, 5'b11111);
      chk(sram_dq_oe == 1'b0, "R1 reset bus released", 32'(sram_dq_oe), 0);
      rst_n = 1'b1;
      model_on = 1'b1;
      @(negedge clk);
      chk(ready && sram_ce_n && !sram_dq_oe, "R1 idle after reset", {ready, sram_ce_n, sram_dq_oe}, 3'b110);

      access(1, 18'h00010, 16'h1234, 2'b11, 0);
      access(0, 18'h00010, 16'h0000, 2'b11, 0);
      access(1, 18'h00010, 16'hABCD, 2'b01, 0);   // R4 low lane only
      access(0, 18'h00010, 16'h0000, 2'b11, 0);
      access(1, 18'h00010, 16'h77FF, 2'b10, 0);   // R4 high lane only
      access(0, 18'h00010, 16'h0000, 2'b01, 0);   // R6 masked read
      access(0, 18'h00010, 16'h0000, 2'b10, 0);
      access(1, 18'h00010, 16'hFFFF, 2'b00, 0);   // R8 zero-mask write
      access(0, 18'h00010, 16'h0000, 2'b11, 0);
      access(0, 18'h00010, 16'h0000, 2'b00, 0);   // R8 zero-mask read
      access(1, 18'h3FFFF, 16'h5AA5, 2'b11, 0);
      access(0, 18'h3FFFF, 16'h0000, 2'b11, 0);
      access(1, 18'h00100, 16'hC3C3, 2'b11, 1);   // R7 request while busy
      access(0, 18'h00200, 16'h0000, 2'b11, 0);   // R7 stray target untouched
      access(0, 18'h00100, 16'h0000, 2'b11, 1);
      for (int i = 0; i < 6; i++) begin
         access(1, AW'(18'h01000 + i * 37), DW'(16'h1111 * (i + 1)), 2'(i % 3 + 1), 0);
      end
      for (int i = 0; i < 6; i++) begin
         access(0, AW'(18'h01000 + i * 37), 16'h0000, 2'b11, 0);
      end
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R7: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule